// File: doc/BRIEF.md
# Address Bus Arbiter with Snoop Retry Recovery

This block decides which master owns the address bus of a split-transaction processor bus. Masters raise request lines and the arbiter answers with one address grant per master. A granted master opens an address tenure with a start strobe, and the tenure closes when the address acknowledge is sampled. If the CPU signals address retry in that closing cycle, the tenure is not committed. The CPU (master 0, the snooping master) then gets the bus at once for its copyback. After the copyback commits, the bus goes back to the master that was retried. That master keeps the bus until it reissues its tenure.

When nobody requests, the grant can be parked on a configured master. The parked master may open a tenure without requesting. Parking can also be switched off, which leaves the bus ungranted. Each committed tenure queues one data tenure. Data grants are issued strictly in commit order, one at a time. Each data grant goes one-hot to the owning master and also raises a strobe for the slave. The data side behaves as a valid/ready stream: the grant is the valid, and the data-tenure-end input is the ready that retires it. The grant holds unchanged until that input is seen, so the data side can stall for as long as it needs. While the queue of pending data tenures is full, no new address grant is issued.

Top module: `abus_arbiter`

## Requirements
- R1: After reset, no address grant, no data grant and no slave strobe is asserted.
- R2: When the bus is free and no retry recovery is pending, the requesting master with the lowest index gets the grant in the following cycle.
- R3: Once a tenure is started (start strobe while granted and idle), the grant stays unchanged until the acknowledge is sampled, whatever the requests do.
- R4: At most one address grant and at most one data grant are asserted in any cycle.
- R5: Retry sampled with the acknowledge of a tenure owned by a master other than 0 moves the grant to master 0 in the next cycle. Master 0 keeps the grant until its own tenure commits.
- R6: After that copyback commits, the grant goes to the retried master in the next cycle. The grant stays there, ahead of any request, until that master starts a tenure.
- R7: Retry sampled at the end of a tenure owned by master 0 has no effect: the tenure commits and queues a data tenure.
- R8: With parking enabled, no request and no recovery pending, the grant goes to the park index. The parked master may start a tenure without requesting.
- R9: With parking disabled and no request and no recovery pending, no address grant is asserted.
- R10: Each committed tenure queues its owner's index. The head of the queue drives a one-hot data grant and the slave strobe, which hold until data-tenure-end and then advance in commit order.
- R11: A retried tenure queues no data tenure.
- R12: While the data queue (4 entries) is full after the current cycle, the bus becomes free without any address grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_MASTERS | Address bus requests, bit i from master i |
| ts_i | input | 1 | Address tenure start by the granted master |
| aack_i | input | 1 | Address tenure end (acknowledge) |
| retry_i | input | 1 | Address retry from the CPU, sampled with aack_i |
| park_en_i | input | 1 | Enables parking of the idle grant |
| park_idx_i | input | IDX_W | Index of the master that receives the parked grant |
| dend_i | input | 1 | Data tenure end; retires the current data grant |
| agnt_o | output | N_MASTERS | Address bus grants, one-hot or zero |
| dgnt_o | output | N_MASTERS | Data bus grant to the owning master, one-hot or zero |
| dslv_gnt_o | output | 1 | Data bus grant strobe to the slave |

## Verification
Retry recovery and data-queue progress can land on the same edge. A retry ends one tenure without queueing, while a data-tenure-end pops the head in that same cycle. A commit can also fill the last free queue slot just as a retry recovery wants to hand the bus to the CPU. The bench aims directed sequences at these collisions, then runs a long random stretch of requests, strobes, retries and data ends. On every clock, all outputs are compared against a behavioural model that tracks the owner, the recovery state and a queue of pending data owners.

// File: rtl/abarb_pkg.sv
package abarb_pkg;
  // Source that decided the next address grant
  typedef enum logic [2:0] {
    SRC_HOLD,     // tenure running, grant frozen
    SRC_BLOCK,    // data queue full, no grant
    SRC_CPU,      // copyback in progress
    SRC_RETRIED,  // hand back to retried master
    SRC_REQ,      // fixed priority among requesters
    SRC_PARK,     // idle, parked master
    SRC_IDLE      // idle, nothing granted
  } arb_src_e;
endpackage

// File: rtl/abarb_prio_sel.sv
module abarb_prio_sel #(
  parameter int N_MASTERS = 4,
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic [N_MASTERS-1:0] req,
  output logic                 found,
  output logic [IDX_W-1:0]     idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_MASTERS - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/abarb_dq.sv
module abarb_dq #(
  parameter int DATA_W = 2,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              valid,
  output logic [DATA_W-1:0] head,
  output logic              full_nxt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_pop;

  assign valid  = (cnt_q != '0);
  assign head   = mem[rd_q];
  assign do_pop = pop && valid;

  always_comb begin
    cnt_d = cnt_q;
    if (push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (!push && do_pop) cnt_d = cnt_q - 1'b1;
  end
  assign full_nxt = (cnt_d == CNT_W'(DEPTH));

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (push) wr_q <= adv(wr_q);
      if (do_pop) rd_q <= adv(rd_q);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/abus_arbiter.sv
module abus_arbiter
  import abarb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int DQ_DEPTH  = 4,
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic                 ts_i,
  input  logic                 aack_i,
  input  logic                 retry_i,
  input  logic                 park_en_i,
  input  logic [IDX_W-1:0]     park_idx_i,
  input  logic                 dend_i,
  output logic [N_MASTERS-1:0] agnt_o,
  output logic [N_MASTERS-1:0] dgnt_o,
  output logic                 dslv_gnt_o
);
  // Address ownership state
  logic             gnt_vld_q, gnt_vld_d;
  logic [IDX_W-1:0] gnt_idx_q, gnt_idx_d;
  logic             busy_q, busy_d;
  // Retry recovery state
  logic             cb_q, cb_d;       // CPU copyback owed
  logic             pend_q, pend_d;   // retried master owed the bus
  logic [IDX_W-1:0] ridx_q, ridx_d;

  logic             start, ended, retry_ok, commit, free_bus;
  logic             rq_found;
  logic [IDX_W-1:0] rq_idx;
  logic             dq_valid, dq_full_nxt;
  logic [IDX_W-1:0] dq_head;
  logic             park_ok;
  arb_src_e         src;

  abarb_prio_sel #(.N_MASTERS(N_MASTERS)) u_prio (
    .req   (req_i),
    .found (rq_found),
    .idx   (rq_idx)
  );

  abarb_dq #(.DATA_W(IDX_W), .DEPTH(DQ_DEPTH)) u_dq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (commit),
    .push_data (gnt_idx_q),
    .pop       (dend_i),
    .valid     (dq_valid),
    .head      (dq_head),
    .full_nxt  (dq_full_nxt)
  );

  assign start    = !busy_q && ts_i && gnt_vld_q;
  assign ended    = busy_q && aack_i;
  assign retry_ok = ended && retry_i && (gnt_idx_q != '0);
  assign commit   = ended && !retry_ok;
  assign free_bus = ended || (!busy_q && !start);
  assign park_ok  = park_en_i && (int'(park_idx_i) < N_MASTERS);

  // Recovery bookkeeping
  always_comb begin
    cb_d   = cb_q;
    pend_d = pend_q;
    ridx_d = ridx_q;
    if (retry_ok) begin
      cb_d   = 1'b1;
      pend_d = 1'b1;
      ridx_d = gnt_idx_q;
    end else if (commit && cb_q && (gnt_idx_q == '0)) begin
      cb_d = 1'b0;
    end
    if (start && pend_q && !cb_q && (gnt_idx_q == ridx_q)) pend_d = 1'b0;
  end

  // Grant source selection, priority order is behaviour
  always_comb begin
    if (!free_bus)        src = SRC_HOLD;
    else if (dq_full_nxt) src = SRC_BLOCK;
    else if (cb_d)        src = SRC_CPU;
    else if (pend_d)      src = SRC_RETRIED;
    else if (rq_found)    src = SRC_REQ;
    else if (park_ok)     src = SRC_PARK;
    else                  src = SRC_IDLE;
  end

  always_comb begin
    gnt_vld_d = 1'b1;
    gnt_idx_d = gnt_idx_q;
    busy_d    = busy_q;
    if (start) busy_d = 1'b1;
    if (ended) busy_d = 1'b0;
    unique case (src)
      SRC_HOLD:    ;
      SRC_CPU:     gnt_idx_d = '0;
      SRC_RETRIED: gnt_idx_d = ridx_d;
      SRC_REQ:     gnt_idx_d = rq_idx;
      SRC_PARK:    gnt_idx_d = park_idx_i;
      default:     begin gnt_vld_d = 1'b0; gnt_idx_d = '0; end
    endcase
    if (src == SRC_HOLD) gnt_vld_d = gnt_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_vld_q <= 1'b0;
      gnt_idx_q <= '0;
      busy_q    <= 1'b0;
      cb_q      <= 1'b0;
      pend_q    <= 1'b0;
      ridx_q    <= '0;
    end else begin
      gnt_vld_q <= gnt_vld_d;
      gnt_idx_q <= gnt_idx_d;
      busy_q    <= busy_d;
      cb_q      <= cb_d;
      pend_q    <= pend_d;
      ridx_q    <= ridx_d;
    end
  end

  // One-hot decode of both grant vectors
  for (genvar g = 0; g < N_MASTERS; g++) begin : g_dec
    assign agnt_o[g] = gnt_vld_q && (gnt_idx_q == IDX_W'(g));
    assign dgnt_o[g] = dq_valid && (dq_head == IDX_W'(g));
  end
  assign dslv_gnt_o = dq_valid;
endmodule

// File: rtl/abus_arbiter_chk.sv
module abus_arbiter_chk #(
  parameter int N_MASTERS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 aack_i,
  input logic                 retry_i,
  input logic                 dend_i,
  input logic                 busy_q,
  input logic [N_MASTERS-1:0] agnt_o,
  input logic [N_MASTERS-1:0] dgnt_o,
  input logic                 dslv_gnt_o
);
  // R4
  addr_gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(agnt_o));

  // R4
  data_gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dgnt_o));

  // R3
  tenure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !aack_i |=> $stable(agnt_o));

  // R5
  retry_to_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && aack_i && retry_i && !agnt_o[0] |=> agnt_o[0] || (agnt_o == '0));

  // R10
  dgnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dslv_gnt_o && !dend_i |=> $stable(dgnt_o) && dslv_gnt_o);
endmodule

bind abus_arbiter abus_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .aack_i     (aack_i),
  .retry_i    (retry_i),
  .dend_i     (dend_i),
  .busy_q     (busy_q),
  .agnt_o     (agnt_o),
  .dgnt_o     (dgnt_o),
  .dslv_gnt_o (dslv_gnt_o)
);

// File: tb/abus_arbiter_tb_top.sv
module abus_arbiter_tb_top;
  localparam int N = 4;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       ts = 1'b0, aack = 1'b0, rt = 1'b0, dend = 1'b0;
  logic       park_en = 1'b0;
  logic [1:0] park_idx = '0;
  logic [3:0] agnt, dgnt;
  logic       dslv;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  // reference model state
  int m_g = -1;
  bit m_busy = 0, m_cb = 0, m_pend = 0;
  int m_ridx = 0;
  int q[$];

  always #5 clk = ~clk;

  abus_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ts_i(ts), .aack_i(aack),
    .retry_i(rt), .park_en_i(park_en), .park_idx_i(park_idx), .dend_i(dend),
    .agnt_o(agnt), .dgnt_o(dgnt), .dslv_gnt_o(dslv)
  );

  function automatic logic [3:0] oh(input int i);
    return (i < 0) ? 4'b0 : 4'(1 << i);
  endfunction

  task automatic model_update();
    bit start, ended, retry_ok, commit, free_b;
    int owner = m_g;
    start    = !m_busy && ts && (m_g >= 0);
    ended    = m_busy && aack;
    retry_ok = ended && rt && (owner != 0);
    commit   = ended && !retry_ok;
    if (dend && q.size() > 0) void'(q.pop_front());
    if (commit) q.push_back(owner);
    free_b = ended || (!m_busy && !start);
    if (start) begin
      m_busy = 1;
      if (m_pend && !m_cb && owner == m_ridx) m_pend = 0;
    end
    if (ended) m_busy = 0;
    if (retry_ok) begin m_cb = 1; m_pend = 1; m_ridx = owner; end
    else if (commit && m_cb && owner == 0) m_cb = 0;
    if (free_b) begin
      if (q.size() == DEPTH) m_g = -1;
      else if (m_cb) m_g = 0;
      else if (m_pend) m_g = m_ridx;
      else if (req != 0) begin
        m_g = -1;
        for (int i = N - 1; i >= 0; i--) if (req[i]) m_g = i;
      end else if (park_en) m_g = int'(park_idx);
      else m_g = -1;
    end
  endtask

  task automatic compare();
    logic [3:0] e_d = (q.size() > 0) ? oh(q[0]) : 4'b0;
    n_cmp++;
    if (agnt !== oh(m_g) || dgnt !== e_d || dslv !== (q.size() > 0)) begin
      n_bad++;
      $display("FAIL %s: agnt=%b dgnt=%b dslv=%b expected agnt=%b dgnt=%b dslv=%b",
               tag, agnt, dgnt, dslv, oh(m_g), e_d, q.size() > 0);
    end
  endtask

  task automatic step(input logic [3:0] r, input logic t, input logic a,
                      input logic y, input logic d);
    req = r; ts = t; aack = a; rt = y; dend = d;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(4'b0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();                         // reset state
    rst_n = 1'b1;
    step(4'b0, 0, 0, 0, 0);            // R9: park off, nothing granted
    tag = "R9"; compare();

    tag = "R2";                        // lowest index wins
    step(4'b0110, 0, 0, 0, 0);
    tag = "R3";
    step(4'b0110, 1, 0, 0, 0);         // master 1 starts
    step(4'b0001, 0, 0, 0, 0);         // CPU request cannot steal
    step(4'b1000, 0, 0, 0, 0);
    tag = "R10";
    step(4'b0100, 0, 1, 0, 0);         // commit master 1 -> queued, grant to 2
    step(4'b0100, 1, 0, 0, 0);         // master 2 starts
    tag = "R11";
    step(4'b0000, 0, 1, 1, 1);         // retried, data of 1 retires same cycle
    tag = "R5";
    step(4'b0010, 0, 0, 0, 0);         // CPU held despite master 1
    step(4'b0010, 1, 0, 0, 0);         // copyback starts
    step(4'b0010, 0, 1, 0, 0);         // copyback commits
    tag = "R6";
    step(4'b0011, 0, 0, 0, 0);         // grant stays on 2
    step(4'b0011, 1, 0, 0, 0);         // 2 reissues
    step(4'b0011, 0, 1, 0, 1);         // commit, data end for CPU
    tag = "R7";
    step(4'b0001, 1, 0, 0, 0);
    step(4'b0000, 0, 1, 1, 0);         // retry on CPU's own tenure ignored
    step(4'b0000, 0, 0, 0, 1);
    step(4'b0000, 0, 0, 0, 1);
    step(4'b0000, 0, 0, 0, 1);
    tag = "R8";
    park_en = 1'b1; park_idx = 2'd3;
    step(4'b0000, 0, 0, 0, 0);         // parked on 3
    step(4'b0000, 1, 0, 0, 0);         // starts without request
    step(4'b0000, 0, 1, 0, 1);
    tag = "R9";
    park_en = 1'b0;
    step(4'b0000, 0, 0, 0, 1);
    idle(2);

    tag = "R12";                       // fill the data queue
    for (int k = 0; k < 5; k++) begin
      step(4'b1100, 0, 0, 0, 0);
      step(4'b1100, 1, 0, 0, 0);
      step(4'b1100, 0, 1, 0, 0);
    end
    idle(2);
    tag = "R10";
    for (int k = 0; k < 6; k++) step(4'b1100, 0, 0, 0, 1);

    tag = "R5";                        // retry when the queue is one from full
    for (int k = 0; k < 3; k++) begin
      step(4'b0100, 1, 0, 0, 0);
      step(4'b0100, 0, 1, 0, 0);
    end
    step(4'b0100, 0, 0, 0, 0);
    step(4'b0100, 1, 0, 0, 0);
    step(4'b0000, 0, 1, 1, 1);         // retry and data end together
    for (int k = 0; k < 8; k++) step(4'b0000, k % 2, (k % 2) == 0, 0, 1);

    tag = "R4";                        // random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      park_en  = ($urandom_range(0, 3) != 0);
      park_idx = 2'($urandom_range(0, 3));
      step(4'($urandom_range(0, 15)), $urandom_range(0, 2) == 0,
           $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 3) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule